// File: doc/BRIEF.md
# Performance Counter Bank with Byte-Wide Snapshot Readout

This block holds a small bank of 16-bit event counters for a receive framer. Each counter advances on a single-cycle pulse from the error detectors. A host reads the bank through an 8-bit register port. Because a count is wider than the bus, the host reads it in two byte accesses. The first access to either byte of a counter returns that byte. In the same cycle it clears the whole counter and copies the other byte into one holding register that all counters share. The host then fetches the remaining byte from the holding register, and that read clears the holding register in turn.

A read is launched by the rising edge of a level strobe, `rd_stb`. A small state machine watches the strobe. In state `RD_IDLE`, a high strobe performs one access and takes transition `START` to state `RD_BUSY`. The machine stays in `RD_BUSY` while the strobe stays high, and takes transition `RELEASE` back to `RD_IDLE` once the strobe drops. The byte that was read is registered. It appears on `rd_data` in the cycle after the access and stays there until the next access. Counter 0 counts parity-bit errors, and it is active only when the channel is set to DS3 C-bit parity framing. The other counters count in every framing mode.

Top module: `pmon_bank`

## Requirements
- R1: After reset, every counter, the holding register and `rd_data` are zero.
- R2: Counter 0 counts only while `frame_mode` is 2'b01 (DS3 C-bit parity). In modes 2'b00, 2'b10 and 2'b11 it is forced to zero from the next cycle on.
- R3: Counter i has its high byte at address 0x58+2i and its low byte at 0x59+2i. The byte addressed is placed on `rd_data` one clock after the strobe rise and is held there until the next access.
- R4: Reading either byte of a counter returns its value from before the read and clears the whole 16-bit counter.
- R5: On that same access, the other byte of the counter (the low byte when the high byte is read, and the high byte when the low byte is read) is stored in the holding register at address 0x6C.
- R6: Reading address 0x6C returns the holding register and clears it to zero.
- R7: An error pulse in the same cycle as a clearing read leaves the counter at 1.
- R8: A counter stops at 0xFFFF and does not wrap.
- R9: Only the first cycle of a high strobe performs an access. Holding the strobe high performs no further clear or capture.
- R10: An access to any other address returns 0x00 and changes no counter and not the holding register.
- R11: Counters 1 to 3 count pulses in every framing mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mode | input | 2 | Framing mode select; 2'b01 is DS3 C-bit parity |
| err_pulse | input | NUM_CNT | One-cycle event pulses, one bit per counter |
| rd_stb | input | 1 | Read strobe; an access happens on its rising edge |
| rd_addr | input | ADDR_W | Register address, sampled with the strobe rise |
| rd_data | output | DATA_W | Registered read data |

## Verification
A counter whose internal value has gone wrong cannot be seen until the host reads it. It then shows up on `rd_data` one clock after that access, and it shows up again through the holding register on the access after that. The bench therefore follows every burst of pulses with a read of both bytes, and it compares `rd_data` with its model on every clock. A state machine that is stuck in `RD_IDLE` shows up on the first strobe held for more than one cycle, because the repeated clear makes the held-over byte come back as zero. A wrong holding value or a missed holding clear shows up on the very next access to 0x6C.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    typedef enum logic [1:0] {
        FM_DS3_M13  = 2'b00,
        FM_DS3_CBIT = 2'b01,
        FM_E3_A     = 2'b10,
        FM_E3_B     = 2'b11
    } frame_mode_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_BUSY = 1'b1
    } rd_state_e;

endpackage

// File: rtl/pmon_rd_fsm.sv
module pmon_rd_fsm
    import pmon_pkg::*;
#(
    parameter int                 NUM_CNT   = 4,
    parameter int                 ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h58,
    parameter logic [ADDR_W-1:0]  HOLD_ADDR = 8'h6C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               fire,
    output logic [NUM_CNT-1:0] cnt_sel,
    output logic               sel_hi,
    output logic               hold_sel,
    output logic               unmapped
);

    localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(2 * NUM_CNT);

    rd_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: START (idle, strobe high), RELEASE (busy, strobe low)
    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: if (rd_stb)  state_nx = RD_BUSY;
            RD_BUSY: if (!rd_stb) state_nx = RD_IDLE;
            default:              state_nx = RD_IDLE;
        endcase
    end

    // outputs: one access per strobe rise
    always_comb begin
        fire = 1'b0;
        unique case (state)
            RD_IDLE: fire = rd_stb;
            RD_BUSY: fire = 1'b0;
            default: fire = 1'b0;
        endcase
    end

    logic [ADDR_W-1:0] offset;
    logic              in_win;
    logic              hold_hit;

    assign offset   = rd_addr - BASE_ADDR;
    assign in_win   = (rd_addr >= BASE_ADDR) && (offset < WIN_SPAN);
    assign hold_hit = (rd_addr == HOLD_ADDR);
    assign sel_hi   = ~offset[0];
    assign hold_sel = fire && hold_hit;
    assign unmapped = fire && !in_win && !hold_hit;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
        assign cnt_sel[i] = fire && in_win && ((offset >> 1) == ADDR_W'(i));
    end

endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_ONE : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/pmon_hold.sv
module pmon_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              clr,
    output logic [DATA_W-1:0] hold
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (load) begin
            hold <= load_val;
        end else if (clr) begin
            hold <= '0;
        end
    end

endmodule

// File: rtl/pmon_bank.sv
module pmon_bank
    import pmon_pkg::*;
#(
    parameter int                 NUM_CNT   = 4,
    parameter int                 DATA_W    = 8,
    parameter int                 ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h58,
    parameter logic [ADDR_W-1:0]  HOLD_ADDR = 8'h6C,
    parameter logic [NUM_CNT-1:0] CBIT_MASK = NUM_CNT'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         frame_mode,
    input  logic [NUM_CNT-1:0] err_pulse,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int CNT_W = 2 * DATA_W;

    logic                            fire;
    logic [NUM_CNT-1:0]              cnt_sel;
    logic                            sel_hi;
    logic                            hold_sel;
    logic                            unmapped;
    logic [NUM_CNT-1:0]              cnt_en;
    logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_arr;
    logic [DATA_W-1:0]               hold_val;
    logic [DATA_W-1:0]               cap_byte;
    logic [DATA_W-1:0]               other_byte;
    logic                            cnt_hit;
    logic                            cbit_mode;
    logic [DATA_W-1:0]               rd_data_q;

    assign cbit_mode = (frame_mode == FM_DS3_CBIT);

    pmon_rd_fsm #(
        .NUM_CNT   (NUM_CNT),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .HOLD_ADDR (HOLD_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .fire     (fire),
        .cnt_sel  (cnt_sel),
        .sel_hi   (sel_hi),
        .hold_sel (hold_sel),
        .unmapped (unmapped)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (CBIT_MASK[i]) begin : g_gated
            assign cnt_en[i] = cbit_mode;
        end else begin : g_free
            assign cnt_en[i] = 1'b1;
        end

        pmon_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cnt_en[i]),
            .inc   (err_pulse[i]),
            .clr   (cnt_sel[i]),
            .cnt   (cnt_arr[i])
        );
    end

    always_comb begin
        cap_byte   = '0;
        other_byte = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cnt_sel[i]) begin
                cap_byte   = sel_hi ? cnt_arr[i][CNT_W-1:DATA_W] : cnt_arr[i][DATA_W-1:0];
                other_byte = sel_hi ? cnt_arr[i][DATA_W-1:0]     : cnt_arr[i][CNT_W-1:DATA_W];
            end
        end
    end

    assign cnt_hit = |cnt_sel;

    pmon_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_hit),
        .load_val (other_byte),
        .clr      (hold_sel),
        .hold     (hold_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (fire) begin
            if (cnt_hit) begin
                rd_data_q <= cap_byte;
            end else if (hold_sel) begin
                rd_data_q <= hold_val;
            end else begin
                rd_data_q <= '0;
            end
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/pmon_bank_chk.sv
module pmon_bank_chk #(
    parameter int                 NUM_CNT   = 4,
    parameter int                 DATA_W    = 8,
    parameter int                 ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h58,
    parameter logic [ADDR_W-1:0]  HOLD_ADDR = 8'h6C,
    parameter logic [NUM_CNT-1:0] CBIT_MASK = NUM_CNT'(1)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [1:0]                        frame_mode,
    input logic [NUM_CNT-1:0]                err_pulse,
    input logic                              fire,
    input logic                              unmapped,
    input logic [ADDR_W-1:0]                 rd_addr,
    input logic [DATA_W-1:0]                 rd_data,
    input logic [DATA_W-1:0]                 hold_val,
    input logic [NUM_CNT-1:0][2*DATA_W-1:0]  cnt_arr
);

    localparam int                CNT_W  = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] C1_HI  = BASE_ADDR + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] C1_LO  = BASE_ADDR + ADDR_W'(3);

    // R9
    one_fire_per_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> (rd_data == '0));

    // R10
    unmapped_hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> (hold_val == $past(hold_val)));

    // R6
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && rd_addr == HOLD_ADDR) |=> (hold_val == '0));

    if (CBIT_MASK[0]) begin : g_gate_chk
        // R2
        cbit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_mode != 2'b01) |=> (cnt_arr[0] == '0));
    end

    if (NUM_CNT > 1 && !CBIT_MASK[1]) begin : g_c1_chk
        // R4
        clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && (rd_addr == C1_HI || rd_addr == C1_LO) && !err_pulse[1])
            |=> (cnt_arr[1] == '0));

        // R5
        hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && rd_addr == C1_HI) |=> (hold_val == $past(cnt_arr[1][DATA_W-1:0])));

        // R8
        saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_arr[1] == {CNT_W{1'b1}} && !(fire && (rd_addr == C1_HI || rd_addr == C1_LO)))
            |=> (cnt_arr[1] == {CNT_W{1'b1}}));
    end

endmodule

bind pmon_bank pmon_bank_chk #(
    .NUM_CNT   (NUM_CNT),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .HOLD_ADDR (HOLD_ADDR),
    .CBIT_MASK (CBIT_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_mode (frame_mode),
    .err_pulse  (err_pulse),
    .fire       (fire),
    .unmapped   (unmapped),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .hold_val   (hold_val),
    .cnt_arr    (cnt_arr)
);

// File: tb/pmon_bank_tb.sv
`timescale 1ns/1ps
module pmon_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] frame_mode = 2'b01;
    logic [3:0] err_pulse = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_vec  = 0;
    int n_fail = 0;

    int m_cnt [4];
    int m_hold;
    int m_rd;
    bit m_prev;

    always #2.5 clk = ~clk;

    pmon_bank u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_mode (frame_mode),
        .err_pulse  (err_pulse),
        .rd_stb     (rd_stb),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    task automatic step(input bit stb, input logic [7:0] addr, input logic [3:0] err, input string tag);
        int  nc [4];
        int  nh;
        int  nr;
        int  idx;
        bit  acc;
        bit  hi;
        bit  en;
        rd_stb    = stb;
        rd_addr   = addr;
        err_pulse = err;
        @(posedge clk);
        acc    = stb && !m_prev;
        m_prev = stb;
        nh = m_hold;
        nr = m_rd;
        idx = -1;
        if (addr >= 8'h58 && addr < 8'h60) idx = (int'(addr) - 'h58) / 2;
        hi = (addr[0] == 1'b0);
        if (acc) begin
            if (idx >= 0) begin
                nr = hi ? (m_cnt[idx] >> 8) : (m_cnt[idx] & 255);
                nh = hi ? (m_cnt[idx] & 255) : (m_cnt[idx] >> 8);
            end else if (addr == 8'h6C) begin
                nr = m_hold;
                nh = 0;
            end else begin
                nr = 0;
            end
        end
        for (int i = 0; i < 4; i++) begin
            en = (i != 0) || (frame_mode == 2'b01);
            if (!en)                          nc[i] = 0;
            else if (acc && idx == i)         nc[i] = err[i] ? 1 : 0;
            else if (err[i] && m_cnt[i] < 65535) nc[i] = m_cnt[i] + 1;
            else                              nc[i] = m_cnt[i];
        end
        for (int i = 0; i < 4; i++) m_cnt[i] = nc[i];
        m_hold = nh;
        m_rd   = nr;
        @(negedge clk);
        n_vec++;
        if (rd_data !== 8'(m_rd)) begin
            n_fail++;
            $display("FAIL %s: addr=%02h rd_data=%02h expected=%02h", tag, addr, rd_data, 8'(m_rd));
        end
    endtask

    task automatic rd(input logic [7:0] addr, input string tag);
        step(1'b1, addr, 4'h0, tag);
        step(1'b0, addr, 4'h0, tag);
    endtask

    task automatic pulses(input logic [3:0] err, input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, 8'h00, err, tag);
    endtask

    initial begin
        #1_250_000;
        n_fail++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_hold = 0; m_rd = 0; m_prev = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every register reads zero
        step(1'b0, 8'h00, 4'h0, "R1");
        for (int a = 'h58; a < 'h60; a++) rd(8'(a), "R1");
        rd(8'h6C, "R1");

        // R2 R3 R4 R5 R6: high byte first, then holding, then cleared
        frame_mode = 2'b01;
        pulses(4'b0001, 5, "R2");
        pulses(4'b0100, 3, "R11");
        rd(8'h58, "R3");
        rd(8'h6C, "R5");
        rd(8'h6C, "R6");
        rd(8'h59, "R4");
        rd(8'h5D, "R3");

        // R5: low byte first hands over the high byte
        pulses(4'b0100, 300, "R5");
        rd(8'h5D, "R5");
        rd(8'h6C, "R5");
        rd(8'h5C, "R4");

        // R7: pulse coincident with the clearing read
        pulses(4'b1000, 4, "R7");
        step(1'b1, 8'h5E, 4'b1000, "R7");
        step(1'b0, 8'h00, 4'h0, "R7");
        rd(8'h5F, "R7");

        // R9: strobe held high, one access only; pulses during hold still count
        pulses(4'b0010, 2, "R9");
        step(1'b1, 8'h5B, 4'h0, "R9");
        step(1'b1, 8'h5B, 4'b0010, "R9");
        step(1'b1, 8'h5B, 4'b0010, "R9");
        step(1'b1, 8'h6C, 4'h0, "R9");
        step(1'b0, 8'h00, 4'h0, "R9");
        rd(8'h5B, "R9");

        // R10: unmapped access leaves counters and holding intact
        pulses(4'b0100, 7, "R10");
        pulses(4'b0010, 1, "R10");
        rd(8'h5D, "R10");
        rd(8'h40, "R10");
        rd(8'h60, "R10");
        rd(8'h6B, "R10");
        rd(8'h6C, "R10");
        rd(8'h5B, "R10");

        // R2 R11: non C-bit modes
        pulses(4'b0001, 4, "R2");
        frame_mode = 2'b10;
        pulses(4'b0011, 6, "R11");
        rd(8'h59, "R2");
        rd(8'h5B, "R11");
        frame_mode = 2'b00;
        pulses(4'b0001, 3, "R2");
        rd(8'h58, "R2");
        frame_mode = 2'b11;
        pulses(4'b0001, 3, "R2");
        rd(8'h59, "R2");
        frame_mode = 2'b01;
        pulses(4'b0001, 2, "R2");
        rd(8'h59, "R2");

        // R8: saturation
        pulses(4'b0010, 70000, "R8");
        rd(8'h5A, "R8");
        rd(8'h6C, "R8");

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] a;
            a = ($urandom_range(0, 7) == 0) ? 8'h6C : 8'($urandom_range('h56, 'h61));
            if (k % 500 == 0) frame_mode = 2'($urandom_range(0, 3));
            step(1'($urandom_range(0, 1)), a, 4'($urandom_range(0, 15)), "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule